// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block produces the time-multiplexed drive pattern for a character STN panel with three common lines and thirty-two segment lines at 1/3 duty, so 96 display points in all. It runs on the slow display clock. It reads a 96-bit word of latched display bits and three mode inputs: bias select, blank and low-power. For every common and every segment line it emits a drive-level code, and an analog stage outside the block turns each code into a voltage.

A frame is cut into three equal common slots of `SLOT_CYCLES` clocks each, which gives 384 clocks per frame by default. The polarity of the whole pattern flips from one frame to the next, so the panel sees no net DC. Blank keeps the scan running but shows every point as off. Low-power freezes the scan where it stands and pulls every line to ground. All outputs are registered.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: While `rstN` is low, all outputs are code 0. The first active clock after release drives common slot 0 in the non-inverted phase.
- R2: The scan holds each common slot for `SLOT_CYCLES` active clocks, in the order 0, 1, 2, and then wraps. A frame is 3 × `SLOT_CYCLES` active clocks.
- R3: Level codes are 0 = ground, 1 = one third, 2 = half, 3 = two thirds, 4 = full supply. With `biasHalf` = 0 (1/3 bias), the selected common is 4 in the non-inverted phase and 0 in the inverted phase. The non-selected commons are 1 in the non-inverted phase and 3 in the inverted phase.
- R4: With `biasHalf` = 1 (1/2 bias), the non-selected commons are code 2. The selected common follows the same phase rule as in R3.
- R5: During slot k, segment s is on when `dispData[k*32+s]` is 1. An on segment takes code 0 in the non-inverted phase and code 4 in the inverted phase.
- R6: An off segment takes code 3 (non-inverted) or 1 (inverted) under 1/3 bias, and code 2 under 1/2 bias.
- R7: The phase inverts at every frame boundary and starts non-inverted after reset.
- R8: While `blank` is 1, every segment is driven as off, whatever the display bits are. The commons keep scanning.
- R9: While `lowPower` is 1, every common and segment output is code 0 and the scan position and phase are frozen. When `lowPower` returns to 0, the scan resumes from the position it was frozen at.
- R10: On every active clock, exactly one common carries a selected level (code 0 or 4) and no output carries a code above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispData | input | 96 | Latched display bits, index k*32+s |
| biasHalf | input | 1 | 0 selects 1/3 bias, 1 selects 1/2 bias |
| blank | input | 1 | Show all points off while scanning |
| lowPower | input | 1 | Freeze scan and ground all outputs |
| comLevel | output | 9 | Common level codes, 3 bits per common line |
| segLevel | output | 96 | Segment level codes, 3 bits per segment line |

## Verification
The hardest case to reach from the ports is low-power arriving on the last clock of a slot or of a frame. In that case the frozen position must keep the pending slot change and the pending phase flip, and apply them on the first clock after wake-up. The stimulus counts clocks from reset and raises low-power exactly on a frame's final active clock. It then keeps low-power high for a while, drops it, and compares the slot and phase that follow. Random toggling of low-power, blank and bias over several thousand clocks then hits the other slot positions.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int unsigned COM_LINES = 3;
  localparam int unsigned LVL_W = 3;

  typedef enum logic [LVL_W-1:0] {
    LVL_GND        = 3'd0,
    LVL_THIRD      = 3'd1,
    LVL_HALF       = 3'd2,
    LVL_TWO_THIRDS = 3'd3,
    LVL_FULL       = 3'd4
  } level_e;

  typedef struct packed {
    logic [COM_LINES-1:0] slotHot;
    logic                 invert;
    logic                 hold;
  } scan_strobe_t;
endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 128
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         lowPower,
  output scan_strobe_t strobe
);
  localparam int unsigned CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam int unsigned IDX_W = (COM_LINES > 1) ? $clog2(COM_LINES) : 1;

  logic [CNT_W-1:0] cycleCnt;
  logic [IDX_W-1:0] slotIdx;
  logic             invert;
  logic             slotEnd;
  logic             frameEnd;

  assign slotEnd  = (cycleCnt == CNT_W'(SLOT_CYCLES - 1));
  assign frameEnd = slotEnd && (slotIdx == IDX_W'(COM_LINES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
      slotIdx  <= '0;
      invert   <= 1'b0;
    end else if (!lowPower) begin
      cycleCnt <= slotEnd ? '0 : cycleCnt + 1'b1;
      if (slotEnd) slotIdx <= frameEnd ? '0 : slotIdx + 1'b1;
      if (frameEnd) invert <= ~invert;
    end
  end

  always_comb begin
    strobe.hold   = lowPower;
    strobe.invert = invert;
    for (int c = 0; c < COM_LINES; c++) begin
      strobe.slotHot[c] = (slotIdx == IDX_W'(c));
    end
  end
endmodule

// File: rtl/lcd_seq_datapath.sv
module lcd_seq_datapath
  import lcd_seq_pkg::*;
#(
  parameter int unsigned SEGS = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  scan_strobe_t               strobe,
  input  logic [COM_LINES*SEGS-1:0]  dispData,
  input  logic                       biasHalf,
  input  logic                       blank,
  output logic [COM_LINES*LVL_W-1:0] comLevel,
  output logic [SEGS*LVL_W-1:0]      segLevel
);
  level_e selLvl, idleComLvl, onSegLvl, offSegLvl;
  logic [COM_LINES*LVL_W-1:0] comNext;
  logic [SEGS*LVL_W-1:0]      segNext;

  always_comb begin
    selLvl     = strobe.invert ? LVL_GND : LVL_FULL;
    onSegLvl   = strobe.invert ? LVL_FULL : LVL_GND;
    idleComLvl = biasHalf ? LVL_HALF : (strobe.invert ? LVL_TWO_THIRDS : LVL_THIRD);
    offSegLvl  = biasHalf ? LVL_HALF : (strobe.invert ? LVL_THIRD : LVL_TWO_THIRDS);
  end

  for (genvar c = 0; c < COM_LINES; c++) begin : g_com
    assign comNext[c*LVL_W +: LVL_W] = strobe.slotHot[c] ? selLvl : idleComLvl;
  end

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    logic [COM_LINES-1:0] column;
    logic                 lit;
    for (genvar k = 0; k < COM_LINES; k++) begin : g_row
      assign column[k] = dispData[k*SEGS + s];
    end
    assign lit = (|(column & strobe.slotHot)) & ~blank;
    assign segNext[s*LVL_W +: LVL_W] = lit ? onSegLvl : offSegLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      comLevel <= '0;
      segLevel <= '0;
    end else if (strobe.hold) begin
      comLevel <= '0;
      segLevel <= '0;
    end else begin
      comLevel <= comNext;
      segLevel <= segNext;
    end
  end
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int unsigned SEGS        = 32,
  parameter int unsigned SLOT_CYCLES = 128
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [COM_LINES*SEGS-1:0]  dispData,
  input  logic                       biasHalf,
  input  logic                       blank,
  input  logic                       lowPower,
  output logic [COM_LINES*LVL_W-1:0] comLevel,
  output logic [SEGS*LVL_W-1:0]      segLevel
);
  scan_strobe_t strobe;

  lcd_seq_ctrl #(.SLOT_CYCLES(SLOT_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .lowPower(lowPower),
    .strobe  (strobe)
  );

  lcd_seq_datapath #(.SEGS(SEGS)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dispData(dispData),
    .biasHalf(biasHalf),
    .blank   (blank),
    .comLevel(comLevel),
    .segLevel(segLevel)
  );
endmodule

// File: rtl/lcd_seq_checker.sv
module lcd_seq_checker
  import lcd_seq_pkg::*;
#(
  parameter int unsigned SEGS = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       biasHalf,
  input logic                       blank,
  input logic                       lowPower,
  input logic [COM_LINES*LVL_W-1:0] comLevel,
  input logic [SEGS*LVL_W-1:0]      segLevel
);
  logic prevRun, prevLp, prevHalf, prevBlank;
  logic [COM_LINES-1:0] comSel, comThird;
  logic [SEGS-1:0]      segExtreme;
  logic                 anyIllegal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRun   <= 1'b0;
      prevLp    <= 1'b0;
      prevHalf  <= 1'b0;
      prevBlank <= 1'b0;
    end else begin
      prevRun   <= !lowPower;
      prevLp    <= lowPower;
      prevHalf  <= biasHalf;
      prevBlank <= blank;
    end
  end

  always_comb begin
    anyIllegal = 1'b0;
    for (int c = 0; c < COM_LINES; c++) begin
      comSel[c]   = (comLevel[c*LVL_W +: LVL_W] == LVL_GND) || (comLevel[c*LVL_W +: LVL_W] == LVL_FULL);
      comThird[c] = (comLevel[c*LVL_W +: LVL_W] == LVL_THIRD) || (comLevel[c*LVL_W +: LVL_W] == LVL_TWO_THIRDS);
      if (comLevel[c*LVL_W +: LVL_W] > LVL_FULL) anyIllegal = 1'b1;
    end
    for (int s = 0; s < SEGS; s++) begin
      segExtreme[s] = (segLevel[s*LVL_W +: LVL_W] == LVL_GND) || (segLevel[s*LVL_W +: LVL_W] == LVL_FULL);
      if (segLevel[s*LVL_W +: LVL_W] > LVL_FULL) anyIllegal = 1'b1;
    end
  end

  // R10: one selected common per active clock
  a_r10_one_selected: assert property (@(posedge clk) disable iff (!rstN)
    prevRun |-> $countones(comSel) == 1);

  // R10: only codes 0..4 appear
  a_r10_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    !anyIllegal);

  // R9: low-power grounds everything
  a_r9_low_power_zero: assert property (@(posedge clk) disable iff (!rstN)
    prevLp |-> (comLevel == '0) && (segLevel == '0));

  // R4: half bias never shows third levels on commons
  a_r4_half_bias_commons: assert property (@(posedge clk) disable iff (!rstN)
    (prevRun && prevHalf) |-> comThird == '0);

  // R8: blank leaves no segment at an extreme level
  a_r8_blank_segments_off: assert property (@(posedge clk) disable iff (!rstN)
    (prevRun && prevBlank && !prevHalf) |-> segExtreme == '0);
endmodule

bind lcd_mux_sequencer lcd_seq_checker #(.SEGS(SEGS)) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .biasHalf(biasHalf),
  .blank   (blank),
  .lowPower(lowPower),
  .comLevel(comLevel),
  .segLevel(segLevel)
);

// File: tb/lcd_mux_sequencer_bench.sv
module lcd_mux_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCOM = 3;
  localparam int NSEG = 32;
  localparam int SLOT = 128;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCOM*NSEG-1:0] dispData = '0;
  logic biasHalf = 1'b0, blank = 1'b0, lowPower = 1'b0;
  logic [NCOM*LW-1:0] comLevel;
  logic [NSEG*LW-1:0] segLevel;

  lcd_mux_sequencer u_lcd_mux_sequencer (
    .clk(clk), .rstN(rstN), .dispData(dispData), .biasHalf(biasHalf),
    .blank(blank), .lowPower(lowPower), .comLevel(comLevel), .segLevel(segLevel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  int mCyc = 0, mSlot = 0;
  bit mPol = 1'b0;
  bit afterReset = 1'b1;
  logic [NCOM*LW-1:0] eCom = '0;
  logic [NSEG*LW-1:0] eSeg = '0;
  string tagCom = "R1", tagSeg = "R1";
  bit eRun = 1'b0, eSlotStart = 1'b0, eFrameStart = 1'b0;
  int eSlot = 0;
  bit ePol = 1'b0;

  function automatic logic [2:0] comCode(bit sel, bit pol, bit half);
    if (sel) return pol ? 3'd0 : 3'd4;
    if (half) return 3'd2;
    return pol ? 3'd3 : 3'd1;
  endfunction

  function automatic logic [2:0] segCode(bit on, bit pol, bit half);
    if (on) return pol ? 3'd4 : 3'd0;
    if (half) return 3'd2;
    return pol ? 3'd1 : 3'd3;
  endfunction

  task automatic check(string tag, logic [NSEG*LW-1:0] act, logic [NSEG*LW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic verify();
    check(tagCom, {{(NSEG-NCOM)*LW{1'b0}}, comLevel}, {{(NSEG-NCOM)*LW{1'b0}}, eCom});
    check(tagSeg, segLevel, eSeg);
    if (eRun) begin
      int nSel = 0;
      int selIdx = -1;
      for (int c = 0; c < NCOM; c++) begin
        if (comLevel[c*LW +: LW] == 3'd0 || comLevel[c*LW +: LW] == 3'd4) begin
          nSel++;
          selIdx = c;
        end
      end
      check("R10", 96'(nSel), 96'(1));
      if (eSlotStart) check("R2", 96'(selIdx), 96'(eSlot));
      if (eFrameStart) check("R7", 96'(comLevel[eSlot*LW +: LW]), 96'(ePol ? 0 : 4));
    end
  endtask

  task automatic predict(bit r, logic [NCOM*NSEG-1:0] d, bit h, bit b, bit lp);
    eSlotStart = 1'b0;
    eFrameStart = 1'b0;
    if (!r) begin
      eCom = '0; eSeg = '0; eRun = 1'b0;
      tagCom = "R1"; tagSeg = "R1";
      mCyc = 0; mSlot = 0; mPol = 1'b0; afterReset = 1'b1;
    end else if (lp) begin
      eCom = '0; eSeg = '0; eRun = 1'b0;
      tagCom = "R9"; tagSeg = "R9";
    end else begin
      eRun = 1'b1;
      for (int c = 0; c < NCOM; c++) eCom[c*LW +: LW] = comCode(c == mSlot, mPol, h);
      for (int s = 0; s < NSEG; s++)
        eSeg[s*LW +: LW] = segCode(d[mSlot*NSEG + s] && !b, mPol, h);
      tagCom = afterReset ? "R1" : (h ? "R4" : "R3");
      tagSeg = b ? "R8" : ((d == '0) ? "R6" : "R5");
      eSlotStart = (mCyc == 0);
      eFrameStart = (mCyc == 0) && (mSlot == 0);
      eSlot = mSlot;
      ePol = mPol;
      afterReset = 1'b0;
      mCyc++;
      if (mCyc == SLOT) begin
        mCyc = 0;
        mSlot++;
        if (mSlot == NCOM) begin
          mSlot = 0;
          mPol = ~mPol;
        end
      end
    end
  endtask

  task automatic step(bit r, logic [NCOM*NSEG-1:0] d, bit h, bit b, bit lp);
    @(negedge clk);
    verify();
    rstN = r; dispData = d; biasHalf = h; blank = b; lowPower = lp;
    predict(r, d, h, b, lp);
  endtask

  function automatic logic [NCOM*NSEG-1:0] rnd96();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    logic [NCOM*NSEG-1:0] d;
    bit h, b, lp;
    void'($urandom(32'd20240607));
    // reset state R1
    repeat (3) step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    // 1/3 bias, random data: R3, R5, R7
    d = rnd96();
    for (int i = 0; i < 2*NCOM*SLOT; i++) begin
      if (i % 97 == 0) d = rnd96();
      step(1'b1, d, 1'b0, 1'b0, 1'b0);
    end
    // 1/2 bias: R4
    for (int i = 0; i < 2*NCOM*SLOT; i++) begin
      if (i % 89 == 0) d = rnd96();
      step(1'b1, d, 1'b1, 1'b0, 1'b0);
    end
    // blank with data present: R8
    for (int i = 0; i < NCOM*SLOT; i++) step(1'b1, '1, i[7], 1'b1, 1'b0);
    // all-off and all-on patterns: R6, R5
    for (int i = 0; i < NCOM*SLOT; i++) step(1'b1, '0, i[6], 1'b0, 1'b0);
    for (int i = 0; i < NCOM*SLOT; i++) step(1'b1, '1, i[6], 1'b0, 1'b0);
    // R9 directed: low-power on the last clock of a frame
    while (!(mCyc == SLOT-1 && mSlot == NCOM-1)) step(1'b1, d, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 25; i++) step(1'b1, d, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 2*SLOT; i++) step(1'b1, d, 1'b0, 1'b0, 1'b0);
    // R9 directed: low-power on the last clock of a slot
    while (mCyc != SLOT-1) step(1'b1, d, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) step(1'b1, d, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < SLOT; i++) step(1'b1, d, 1'b1, 1'b0, 1'b0);
    // constrained random mix
    h = 1'b0; b = 1'b0; lp = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 50 == 0) d = rnd96();
      if ($urandom % 40 == 0) lp = ~lp;
      if ($urandom % 60 == 0) b = ~b;
      if ($urandom % 60 == 0) h = ~h;
      step(1'b1, d, h, b, lp);
    end
    // mid-frame reset then restart: R1
    for (int i = 0; i < 2; i++) step(1'b0, d, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < NCOM*SLOT + 10; i++) step(1'b1, d, 1'b0, 1'b0, 1'b0);
    step(1'b1, d, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule